// File: doc/BRIEF.md
# Trap Arbitration Controller

This block decides when a small in-order core leaves its normal instruction stream, and why. It receives fault flags for the instruction in decode/execute, load and store error flags for the memory operation in the writeback stage, and a set of interrupt requests. From these it picks one trap, records its cause code, and then steers the fetch unit to the handler through a flush and PC-set sequence. It also handles the return instruction, tracks whether a non-maskable interrupt is being serviced, and shows the raw interrupt requests to the CSR logic.

A parameter selects whether the core has a separate writeback stage. With that stage present, the writeback instruction is older than the one in decode. Its memory error therefore outranks a younger decode fault, and decode faults and interrupts wait while the memory operation is still outstanding. Without that stage, the load/store error belongs to the decode instruction itself and ranks below its other faults.

Every trap is captured in a register first and acted on in a separate FLUSH cycle. No fault input reaches the PC-set output combinationally.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the block stays idle until `fetch_req_i` is seen. While idle it raises no flush or PC-set, and it ignores every fault and interrupt.
- R2: A trap detected in cycle t causes no PC-set in cycle t. In cycle t+1 only, `flush_o`, `pc_set_o` and `save_pc_o` are high, `pc_sel_o` is 2'b01 (handler) and `cause_o` holds the trap code.
- R3: Decode faults count only while `id_valid_i` is high. Their priority and codes are: fetch error (1) over illegal instruction (2) over ecall (11) over ebreak (3). `cause_o[31]` is 0 for all faults.
- R4: With the writeback stage present, a store error (7) beats a load error (5), and both beat any decode fault raised in the same cycle. They need no `id_valid_i`.
- R5: Without the writeback stage, decode faults beat load/store errors raised in the same cycle.
- R6: With the writeback stage present, a decode fault is not acted on while `wb_outstanding_i` is high. It is taken once that input falls. Without that stage, `wb_outstanding_i` has no effect.
- R7: An interrupt is held while a valid memory operation sits in decode (`id_mem_op_i`). In the writeback configuration it is also held while `wb_outstanding_i` is high.
- R8: `irq_pending_o` shows the raw requests whatever the enables are: bit 0 software, bit 1 timer, bit 2 external, bit 3+i fast line i. A maskable interrupt is taken only when its request bit, the same bit of `irq_en_i` and `irq_global_en_i` are all high.
- R9: Interrupt causes have bit 31 set, with codes software 3, timer 7, external 11, fast line i 16+i and NMI 31. The priority is NMI, then fast lines from the highest index down, then external, software and timer. Any fault beats an interrupt.
- R10: Taking an NMI sets `nmi_mode_o`. While it is set, every interrupt, NMI included, is ignored. A valid return (`id_mret_i`) raises `pc_set_o` in the same cycle with `pc_sel_o` 2'b10 and clears `nmi_mode_o` on the next edge. `restore_stack_o` is high with the return only when `nmi_mode_o` was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | First instruction has been requested |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| id_fetch_err_i | input | 1 | Decode instruction had a fetch error |
| id_illegal_i | input | 1 | Decode instruction is illegal |
| id_ecall_i | input | 1 | Decode instruction is an environment call |
| id_ebreak_i | input | 1 | Decode instruction is a breakpoint |
| id_mem_op_i | input | 1 | Decode instruction is a load or store |
| id_mret_i | input | 1 | Decode instruction is a trap return |
| wb_outstanding_i | input | 1 | Writeback has an unfinished memory operation |
| wb_load_err_i | input | 1 | Load error reported |
| wb_store_err_i | input | 1 | Store error reported |
| irq_sw_i | input | 1 | Software interrupt request |
| irq_timer_i | input | 1 | Timer interrupt request |
| irq_ext_i | input | 1 | External interrupt request |
| irq_fast_i | input | NFAST | Fast interrupt requests |
| irq_nmi_i | input | 1 | Non-maskable interrupt request |
| irq_en_i | input | NFAST+3 | Per-line enables, same bit order as `irq_pending_o` |
| irq_global_en_i | input | 1 | Global interrupt enable |
| flush_o | output | 1 | Flush the pipeline |
| pc_set_o | output | 1 | Load a new PC |
| pc_sel_o | output | 2 | PC source: 01 handler, 10 return address |
| cause_o | output | 32 | Cause of the last trap taken |
| save_pc_o | output | 1 | Save the trapping PC |
| nmi_mode_o | output | 1 | NMI service in progress |
| restore_stack_o | output | 1 | Restore the saved status stack on return |
| irq_pending_o | output | NFAST+3 | Raw interrupt requests |

## Verification
The assertions check several rules on every cycle: PC-set with the handler select only follows a registered trap, a flush never lasts two cycles, the idle state stays silent, interrupts are never taken in NMI mode or while a memory operation drains, and a writeback error always wins the recorded cause. Only the bench scenarios can show the exact cause code produced for each mix of simultaneous faults and interrupts. They also show that the two configurations rank load/store errors differently, that a deferred fault or interrupt is actually taken once the drain ends, and that the return restores the status stack only in NMI mode.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned CAUSE_W = 32;
  localparam int unsigned CODE_W  = 5;

  typedef enum logic [1:0] {
    PCS_NONE = 2'd0,
    PCS_EXC  = 2'd1,
    PCS_RET  = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } ctl_state_e;

  // fault codes
  localparam logic [CODE_W-1:0] EXC_FETCH   = 5'd1;
  localparam logic [CODE_W-1:0] EXC_ILLEGAL = 5'd2;
  localparam logic [CODE_W-1:0] EXC_EBREAK  = 5'd3;
  localparam logic [CODE_W-1:0] EXC_LOAD    = 5'd5;
  localparam logic [CODE_W-1:0] EXC_STORE   = 5'd7;
  localparam logic [CODE_W-1:0] EXC_ECALL   = 5'd11;

  // interrupt codes
  localparam logic [CODE_W-1:0] IRQ_SW        = 5'd3;
  localparam logic [CODE_W-1:0] IRQ_TIMER     = 5'd7;
  localparam logic [CODE_W-1:0] IRQ_EXT       = 5'd11;
  localparam int unsigned       IRQ_FAST_BASE = 16;
  localparam logic [CODE_W-1:0] IRQ_NMI       = 5'd31;

  function automatic logic [CAUSE_W-1:0] mk_cause(input logic is_irq,
                                                  input logic [CODE_W-1:0] code);
    return {is_irq, {(CAUSE_W-CODE_W-1){1'b0}}, code};
  endfunction

  function automatic logic [CODE_W-1:0] fast_code(input int unsigned idx);
    return CODE_W'(IRQ_FAST_BASE + idx);
  endfunction

endpackage

// File: rtl/trap_fault_sel.sv
module trap_fault_sel
  import trap_pkg::*;
#(
  parameter bit WB_STAGE = 1'b1
) (
  input  logic              id_valid_i,
  input  logic              fetch_err_i,
  input  logic              illegal_i,
  input  logic              ecall_i,
  input  logic              ebreak_i,
  input  logic              load_err_i,
  input  logic              store_err_i,
  output logic              id_fault_o,
  output logic              lsu_fault_o,
  output logic              lsu_wins_o,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] id_code;
  logic [CODE_W-1:0] lsu_code;

  assign id_fault_o  = id_valid_i & (fetch_err_i | illegal_i | ecall_i | ebreak_i);
  assign lsu_fault_o = load_err_i | store_err_i;

  always_comb begin
    if (fetch_err_i)      id_code = EXC_FETCH;
    else if (illegal_i)   id_code = EXC_ILLEGAL;
    else if (ecall_i)     id_code = EXC_ECALL;
    else                  id_code = EXC_EBREAK;
  end

  assign lsu_code = store_err_i ? EXC_STORE : EXC_LOAD;

  generate
    if (WB_STAGE) begin : g_wb_first
      // the writeback instruction is older: its error wins
      assign lsu_wins_o = lsu_fault_o;
    end else begin : g_id_first
      // error belongs to the decode instruction: its other faults win
      assign lsu_wins_o = lsu_fault_o & ~id_fault_o;
    end
  endgenerate

  assign code_o = lsu_wins_o ? lsu_code : id_code;

endmodule

// File: rtl/trap_irq_sel.sv
module trap_irq_sel
  import trap_pkg::*;
#(
  parameter int unsigned NFAST = 15,
  localparam int unsigned NIRQ = NFAST + 3
) (
  input  logic [NIRQ-1:0]   pend_i,
  input  logic [NIRQ-1:0]   en_i,
  input  logic              global_en_i,
  input  logic              nmi_i,
  input  logic              nmi_mode_i,
  output logic              req_o,
  output logic              nmi_o,
  output logic [CODE_W-1:0] code_o
);

  logic [NIRQ-1:0]   armed;
  logic [CODE_W-1:0] fast_tbl [NFAST];

  assign armed = pend_i & en_i & {NIRQ{global_en_i}};

  for (genvar i = 0; i < NFAST; i++) begin : g_fast_code
    assign fast_tbl[i] = fast_code(i);
  end

  always_comb begin
    req_o  = 1'b0;
    nmi_o  = 1'b0;
    code_o = '0;
    if (!nmi_mode_i) begin
      if (nmi_i) begin
        req_o  = 1'b1;
        nmi_o  = 1'b1;
        code_o = IRQ_NMI;
      end else begin
        req_o = |armed;
        // lowest priority first, later hits overwrite
        if (armed[1]) code_o = IRQ_TIMER;
        if (armed[0]) code_o = IRQ_SW;
        if (armed[2]) code_o = IRQ_EXT;
        for (int i = 0; i < NFAST; i++) begin
          if (armed[3+i]) code_o = fast_tbl[i];
        end
      end
    end
  end

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
#(
  parameter bit WB_STAGE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_req_i,
  input  logic               id_valid_i,
  input  logic               id_mem_op_i,
  input  logic               id_mret_i,
  input  logic               wb_outstanding_i,
  input  logic               id_fault_i,
  input  logic               lsu_fault_i,
  input  logic [CODE_W-1:0]  fault_code_i,
  input  logic               irq_req_i,
  input  logic               irq_nmi_i,
  input  logic [CODE_W-1:0]  irq_code_i,
  output logic               flush_o,
  output logic               pc_set_o,
  output pc_sel_e            pc_sel_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               save_pc_o,
  output logic               nmi_mode_o,
  output logic               restore_stack_o,
  output logic               trap_go_o,
  output logic               irq_go_o
);

  ctl_state_e         state_q, state_d;
  logic [CAUSE_W-1:0] cause_q;
  logic               nmi_mode_q;
  logic               wb_busy;
  logic               running;
  logic               fault_wait;
  logic               fault_go;
  logic               irq_hold;
  logic               irq_go;
  logic               ret_go;

  generate
    if (WB_STAGE) begin : g_wb_busy
      assign wb_busy = wb_outstanding_i;
    end else begin : g_no_wb
      assign wb_busy = 1'b0;
    end
  endgenerate

  assign running    = (state_q == ST_RUN);
  assign fault_wait = id_fault_i & ~lsu_fault_i & wb_busy;
  assign fault_go   = running & (id_fault_i | lsu_fault_i) & ~fault_wait;
  assign irq_hold   = (id_valid_i & id_mem_op_i) | wb_busy;
  assign irq_go     = running & irq_req_i & ~irq_hold & ~fault_go & ~fault_wait;
  assign ret_go     = running & id_valid_i & id_mret_i & ~fault_go & ~fault_wait & ~irq_go;

  assign trap_go_o = fault_go | irq_go;
  assign irq_go_o  = irq_go;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fetch_req_i) state_d = ST_RUN;
      ST_RUN:   if (trap_go_o)   state_d = ST_FLUSH;
      ST_FLUSH: state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cause_q    <= '0;
      nmi_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (trap_go_o) cause_q <= mk_cause(irq_go, irq_go ? irq_code_i : fault_code_i);
      if (irq_go && irq_nmi_i) nmi_mode_q <= 1'b1;
      else if (ret_go)         nmi_mode_q <= 1'b0;
    end
  end

  assign flush_o         = (state_q == ST_FLUSH);
  assign save_pc_o       = (state_q == ST_FLUSH);
  assign pc_set_o        = (state_q == ST_FLUSH) | ret_go;
  assign pc_sel_o        = (state_q == ST_FLUSH) ? PCS_EXC : (ret_go ? PCS_RET : PCS_NONE);
  assign cause_o         = cause_q;
  assign nmi_mode_o      = nmi_mode_q;
  assign restore_stack_o = ret_go & nmi_mode_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!pc_set_o && !flush_o && !trap_go_o));

  // R2
  handler_after_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o == PCS_EXC) |-> $past(trap_go_o));

  // R2
  flush_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  // R6
  fault_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && id_fault_i && !lsu_fault_i && wb_outstanding_i && WB_STAGE) |=> !flush_o);

  // R7
  irq_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_go |-> (!(id_valid_i && id_mem_op_i) && !(WB_STAGE && wb_outstanding_i)));

  // R10
  nmi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_mode_q |-> !irq_go);

  // R9
  cause_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o == PCS_EXC) |-> (cause_o[CAUSE_W-1] == $past(irq_go)));

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter bit          WB_STAGE = 1'b1,
  parameter int unsigned NFAST    = 15,
  localparam int unsigned NIRQ    = NFAST + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic              id_valid_i,
  input  logic              id_fetch_err_i,
  input  logic              id_illegal_i,
  input  logic              id_ecall_i,
  input  logic              id_ebreak_i,
  input  logic              id_mem_op_i,
  input  logic              id_mret_i,
  input  logic              wb_outstanding_i,
  input  logic              wb_load_err_i,
  input  logic              wb_store_err_i,
  input  logic              irq_sw_i,
  input  logic              irq_timer_i,
  input  logic              irq_ext_i,
  input  logic [NFAST-1:0]  irq_fast_i,
  input  logic              irq_nmi_i,
  input  logic [NIRQ-1:0]   irq_en_i,
  input  logic              irq_global_en_i,
  output logic              flush_o,
  output logic              pc_set_o,
  output logic [1:0]        pc_sel_o,
  output logic [31:0]       cause_o,
  output logic              save_pc_o,
  output logic              nmi_mode_o,
  output logic              restore_stack_o,
  output logic [NIRQ-1:0]   irq_pending_o
);

  logic              id_fault;
  logic              lsu_fault;
  logic              lsu_wins;
  logic [CODE_W-1:0] fault_code;
  logic              irq_req;
  logic              irq_nmi;
  logic [CODE_W-1:0] irq_code;
  logic              trap_go;
  logic              irq_go;
  pc_sel_e           pc_sel;

  // raw requests, independent of enables
  assign irq_pending_o = {irq_fast_i, irq_ext_i, irq_timer_i, irq_sw_i};

  trap_fault_sel #(.WB_STAGE(WB_STAGE)) u_fault_sel (
    .id_valid_i  (id_valid_i),
    .fetch_err_i (id_fetch_err_i),
    .illegal_i   (id_illegal_i),
    .ecall_i     (id_ecall_i),
    .ebreak_i    (id_ebreak_i),
    .load_err_i  (wb_load_err_i),
    .store_err_i (wb_store_err_i),
    .id_fault_o  (id_fault),
    .lsu_fault_o (lsu_fault),
    .lsu_wins_o  (lsu_wins),
    .code_o      (fault_code)
  );

  trap_irq_sel #(.NFAST(NFAST)) u_irq_sel (
    .pend_i      (irq_pending_o),
    .en_i        (irq_en_i),
    .global_en_i (irq_global_en_i),
    .nmi_i       (irq_nmi_i),
    .nmi_mode_i  (nmi_mode_o),
    .req_o       (irq_req),
    .nmi_o       (irq_nmi),
    .code_o      (irq_code)
  );

  trap_fsm #(.WB_STAGE(WB_STAGE)) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .fetch_req_i      (fetch_req_i),
    .id_valid_i       (id_valid_i),
    .id_mem_op_i      (id_mem_op_i),
    .id_mret_i        (id_mret_i),
    .wb_outstanding_i (wb_outstanding_i),
    .id_fault_i       (id_fault),
    .lsu_fault_i      (lsu_fault),
    .fault_code_i     (fault_code),
    .irq_req_i        (irq_req),
    .irq_nmi_i        (irq_nmi),
    .irq_code_i       (irq_code),
    .flush_o          (flush_o),
    .pc_set_o         (pc_set_o),
    .pc_sel_o         (pc_sel),
    .cause_o          (cause_o),
    .save_pc_o        (save_pc_o),
    .nmi_mode_o       (nmi_mode_o),
    .restore_stack_o  (restore_stack_o),
    .trap_go_o        (trap_go),
    .irq_go_o         (irq_go)
  );

  assign pc_sel_o = pc_sel;

  // R4
  wb_error_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WB_STAGE && lsu_fault && trap_go) |=>
      (!cause_o[31] && (cause_o[4:0] == EXC_LOAD || cause_o[4:0] == EXC_STORE)));

  // R5
  id_fault_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WB_STAGE && id_fault && trap_go) |=> !lsu_wins || $past(!id_fault));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_go && !irq_nmi) |-> (irq_global_en_i && |(irq_pending_o & irq_en_i)));

endmodule

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;

  localparam int unsigned NFAST = 15;
  localparam int unsigned NIRQ  = NFAST + 3;
  localparam logic [31:0] NONE  = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic fetch_req, idv, fe, il, ec, eb, mem, mret, wbo, le, se;
  logic sw, tm, ext, nmi, gen;
  logic [NFAST-1:0] fast;
  logic [NIRQ-1:0]  en;

  logic        a_flush, a_pcset, a_save, a_nmim, a_rest;
  logic [1:0]  a_sel;
  logic [31:0] a_cause;
  logic [NIRQ-1:0] a_pend;
  logic        b_flush, b_pcset, b_save, b_nmim, b_rest;
  logic [1:0]  b_sel;
  logic [31:0] b_cause;
  logic [NIRQ-1:0] b_pend;

  trap_ctrl #(.WB_STAGE(1'b1), .NFAST(NFAST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_req_i(fetch_req), .id_valid_i(idv),
    .id_fetch_err_i(fe), .id_illegal_i(il), .id_ecall_i(ec), .id_ebreak_i(eb),
    .id_mem_op_i(mem), .id_mret_i(mret), .wb_outstanding_i(wbo),
    .wb_load_err_i(le), .wb_store_err_i(se), .irq_sw_i(sw), .irq_timer_i(tm),
    .irq_ext_i(ext), .irq_fast_i(fast), .irq_nmi_i(nmi), .irq_en_i(en),
    .irq_global_en_i(gen), .flush_o(a_flush), .pc_set_o(a_pcset), .pc_sel_o(a_sel),
    .cause_o(a_cause), .save_pc_o(a_save), .nmi_mode_o(a_nmim),
    .restore_stack_o(a_rest), .irq_pending_o(a_pend));

  trap_ctrl #(.WB_STAGE(1'b0), .NFAST(NFAST)) dut_two (
    .clk_i(clk), .rst_ni(rst_n), .fetch_req_i(fetch_req), .id_valid_i(idv),
    .id_fetch_err_i(fe), .id_illegal_i(il), .id_ecall_i(ec), .id_ebreak_i(eb),
    .id_mem_op_i(mem), .id_mret_i(mret), .wb_outstanding_i(wbo),
    .wb_load_err_i(le), .wb_store_err_i(se), .irq_sw_i(sw), .irq_timer_i(tm),
    .irq_ext_i(ext), .irq_fast_i(fast), .irq_nmi_i(nmi), .irq_en_i(en),
    .irq_global_en_i(gen), .flush_o(b_flush), .pc_set_o(b_pcset), .pc_sel_o(b_sel),
    .cause_o(b_cause), .save_pc_o(b_save), .nmi_mode_o(b_nmim),
    .restore_stack_o(b_rest), .irq_pending_o(b_pend));

  typedef struct packed {
    logic idv, fe, il, ec, eb, le, se, mem;
    logic [17:0] pend;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h0,     32'h0000_0001}, // R3 fetch
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 18'h0,     32'h0000_0002}, // R3 illegal
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 18'h0,     32'h0000_000B}, // R3 ecall
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 18'h0,     32'h0000_0003}, // R3 ebreak
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h0,     NONE},          // R3 no valid
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h0,     32'h0000_0005}, // R4 load wins
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 18'h0,     32'h0000_0007}, // R4 store
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h3,     32'h8000_0003}, // R9 sw>timer
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h2,     32'h8000_0007}, // R9 timer
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h5,     32'h8000_000B}, // R9 ext
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'hC,     32'h8000_0010}, // R9 fast0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h20040, 32'h8000_001E}, // R9 fast14
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h1,     32'h0000_0002}, // R9 fault>irq
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 18'h1,     NONE},          // R7 mem in id
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h1,     32'h8000_0003}  // R9 sw
  };

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    idv = 0; fe = 0; il = 0; ec = 0; eb = 0; mem = 0; mret = 0;
    wbo = 0; le = 0; se = 0; sw = 0; tm = 0; ext = 0; nmi = 0; fast = '0;
  endtask

  task automatic drive_vec(input vec_t v);
    idv = v.idv; fe = v.fe; il = v.il; ec = v.ec; eb = v.eb;
    le = v.le; se = v.se; mem = v.mem;
    sw = v.pend[0]; tm = v.pend[1]; ext = v.pend[2]; fast = v.pend[17:3];
  endtask

  task automatic expect_trap(input string req, input logic [31:0] exp);
    check(a_pcset && a_flush && a_save && a_sel == 2'b01 && a_cause == exp,
          req, a_cause, exp);
  endtask

  initial begin
    clear_in();
    fetch_req = 0; gen = 1; en = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!a_pcset && !a_flush && !a_save && !a_nmim && a_cause == 0, "R1 reset",
          {a_pcset, a_flush, a_cause[29:0]}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R1: faults ignored before the first fetch
    idv = 1; fe = 1; le = 1;
    @(negedge clk); clear_in(); #1;
    check(!a_pcset && !a_flush, "R1 idle ignores faults", {31'b0, a_pcset}, 32'h0);
    // R8: raw pending with enables off
    en = '0; sw = 1; fast[14] = 1; #1;
    check(a_pend == 18'h20001, "R8 raw pending", {14'b0, a_pend}, 32'h20001);
    clear_in(); en = '1;
    fetch_req = 1; @(negedge clk); fetch_req = 0;
    @(negedge clk);

    // vector table
    for (int k = 0; k < NV; k++) begin
      drive_vec(VECS[k]); #1;
      check(!a_pcset, "R2 no same-cycle pc_set", {31'b0, a_pcset}, 32'h0);
      @(negedge clk); clear_in(); #1;
      if (VECS[k].exp == NONE)
        check(!a_pcset && !a_flush, "R3/R7 no trap", {31'b0, a_pcset}, 32'h0);
      else
        expect_trap("R2/R3/R4/R9 vector", VECS[k].exp);
      @(negedge clk); #1;
      check(!a_flush, "R2 one flush cycle", {31'b0, a_flush}, 32'h0);
      @(negedge clk);
    end

    // R8: global enable off, then line enable off
    gen = 0; tm = 1;
    @(negedge clk); #1;
    check(!a_pcset, "R8 global off", {31'b0, a_pcset}, 32'h0);
    gen = 1; en[1] = 0;
    @(negedge clk); #1;
    check(!a_pcset, "R8 line enable off", {31'b0, a_pcset}, 32'h0);
    clear_in(); en = '1;
    repeat (2) @(negedge clk);

    // R6: decode fault waits on outstanding writeback
    wbo = 1; idv = 1; il = 1;
    @(negedge clk); #1;
    check(!a_pcset, "R6 fault waits", {31'b0, a_pcset}, 32'h0);
    check(b_pcset && b_cause == 32'h2, "R6 two-stage no wait", b_cause, 32'h2);
    @(negedge clk); #1;
    check(!a_pcset, "R6 still waiting", {31'b0, a_pcset}, 32'h0);
    wbo = 0;
    @(negedge clk); clear_in(); #1;
    expect_trap("R6 fault after drain", 32'h2);
    repeat (3) @(negedge clk);

    // R5 vs R4: same faults, different configuration
    idv = 1; fe = 1; le = 1;
    @(negedge clk); clear_in(); #1;
    check(b_pcset && b_cause == 32'h1, "R5 two-stage fetch wins", b_cause, 32'h1);
    expect_trap("R4 writeback load wins", 32'h5);
    repeat (2) @(negedge clk);

    // R7: interrupt held while writeback drains
    wbo = 1; ext = 1;
    @(negedge clk); #1;
    check(!a_pcset, "R7 irq held", {31'b0, a_pcset}, 32'h0);
    @(negedge clk); #1;
    check(!a_pcset, "R7 irq still held", {31'b0, a_pcset}, 32'h0);
    wbo = 0;
    @(negedge clk); clear_in(); #1;
    expect_trap("R7 irq after drain", 32'h8000_000B);
    repeat (3) @(negedge clk);

    // R10: NMI
    nmi = 1; fast[14] = 1;
    @(negedge clk); #1;
    expect_trap("R10 nmi cause", 32'h8000_001F);
    check(a_nmim, "R10 nmi mode set", {31'b0, a_nmim}, 32'h1);
    sw = 1;
    repeat (3) begin
      @(negedge clk); #1;
      check(!a_pcset, "R10 irq ignored in nmi", {31'b0, a_pcset}, 32'h0);
    end
    clear_in();
    idv = 1; mret = 1; #1;
    check(a_pcset && a_sel == 2'b10 && a_rest, "R10 return restores",
          {29'b0, a_pcset, a_sel}, 32'h6);
    @(negedge clk); #1;
    check(!a_nmim, "R10 nmi mode cleared", {31'b0, a_nmim}, 32'h0);
    check(a_pcset && a_sel == 2'b10 && !a_rest, "R10 plain return",
          {29'b0, a_rest, a_sel}, 32'h2);
    @(negedge clk); clear_in();
    repeat (2) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule